// File: doc/BRIEF.md
# Fractional-N Synthesizer Parameter Controller

This block turns a requested output frequency and a reference frequency (both in hertz, unsigned integers) into the two programming fields of a fractional-N synthesizer: an integer multiplier field `nd` and a 22-bit fraction `fracr`. The synthesizer then runs at reference × ((nd + 1) + fracr / 2^22). The block also reports the exact frequency the chosen fields produce and flags requests that cannot be met. Both divisions it needs go through one shared bit-serial restoring divider, so a request takes a fixed number of cycles.

A second, independent part of the block issues the register writes that switch the synthesizer on and off. Each write is a masked command {register index, mask, data}, offered one per cycle under a valid/ready handshake. Switching on holds the synthesizer in reset, releases it, loads the fraction, and only then enables it together with the multiplier. Switching off undoes this in the reverse order, in two separate writes.

A request is made with a one-cycle `start` pulse. `clamp_en` picks between a mode that pulls the request into the legal 620 MHz to 700 MHz window and a mode that rejects anything outside it.

Top module: `frac_pll_ctrl`

## Requirements
- R1: With `clamp_en` = 1, a request below 620,000,000 (zero included) is treated as 620,000,000, and a request above 700,000,000 is treated as 700,000,000, before the fields are derived.
- R2: With `clamp_en` = 0, a request below 620,000,000 (zero included) or above 700,000,000 ends with `err` = 1.
- R3: With q = floor(effective rate / reference), the result is nd = q − 1. A zero reference, q = 0, or q ≥ 127 (the all-ones value of the 7-bit nd field) ends with `err` = 1.
- R4: With r the remainder of that division, fracr = floor((r × 2^22 + floor(reference / 2)) / reference), so a half is rounded up. When that value reaches 2^22 the request ends with `err` = 1.
- R5: On success, `rate_out` = reference × (nd + 1) + floor((reference × fracr + 2^21) / 2^22).
- R6: `busy` is high from the cycle after an accepted `start` while the divider works. `done` is a one-cycle pulse, `err` is valid in that cycle, and `busy` is low in it. A request rejected by R2, or by a zero reference, gives `done` one cycle after `start` with `busy` never high. `start` is ignored while a request is in progress.
- R7: After reset, `busy`, `done`, `err`, `cmd_valid`, `nd`, `fracr` and `rate_out` are zero. A request that ends with `err` = 1 leaves `nd`, `fracr` and `rate_out` at their previous values.
- R8: A `pll_on` pulse produces four commands in this order: register 0, mask 0x1, data 0; register 0, mask 0x1, data 0x1; register 1, mask 0x3FFFFF, data fracr; register 0, mask 0x1FE, data 0x2 | (nd << 2). In register 0, bit 0 releases the synthesizer from reset, bit 1 enables it, and bits 8:2 hold nd. In register 1, bits 21:0 hold fracr. `cmd_reg` carries the register index.
- R9: A `pll_off` pulse produces two commands: register 0, mask 0x2, data 0, then register 0, mask 0x1, data 0.
- R10: A command is consumed only in a cycle with `cmd_valid` and `cmd_ready` both high. While `cmd_ready` is low, `cmd_valid`, `cmd_reg`, `cmd_mask` and `cmd_data` hold.
- R11: `pll_on` and `pll_off` are ignored while a command sequence is in progress. If both arrive in the same cycle, the switch-on sequence runs. The switch-on sequence uses the `nd` and `fracr` held when `pll_on` was accepted, even if a later request changes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a parameter request |
| clamp_en | input | 1 | 1: clamp request into range, 0: reject out of range |
| req_rate | input | 32 | Requested output frequency in Hz |
| ref_rate | input | 32 | Reference frequency in Hz |
| busy | output | 1 | Divider is working |
| done | output | 1 | One-cycle result pulse |
| err | output | 1 | Request rejected, valid with done |
| nd | output | 7 | Integer multiplier field (multiplier minus one) |
| fracr | output | 22 | Fractional field |
| rate_out | output | 32 | Exact frequency produced by nd and fracr |
| pll_on | input | 1 | Start the switch-on write sequence |
| pll_off | input | 1 | Start the switch-off write sequence |
| cmd_valid | output | 1 | A command is offered |
| cmd_ready | input | 1 | Consumer takes the offered command |
| cmd_reg | output | 1 | Target register index |
| cmd_mask | output | 32 | Bits the command changes |
| cmd_data | output | 32 | New values for the masked bits |

## Verification
The rarest outcome is a fraction that rounds up to exactly 2^22. It needs a remainder of reference − 1 with a reference of at least 2^23, so the stimulus picks a 10 MHz reference and asks for one hertz below a multiple of it. The exact half-way rounding case is reached the same way, with a 2^23 Hz reference and a remainder of one. The capture of fields into the switch-on sequence is exercised by holding `cmd_ready` low, launching a new request that changes `nd`, and only then draining the commands.

// File: rtl/frac_pll_ctrl.sv
module frac_pll_ctrl #(
  parameter int RATE_W = 32,
  parameter int FRAC_W = 22,
  parameter int ND_W   = 7,
  parameter int REG_W  = 32,
  parameter int ND_LSB = 2,
  parameter logic [RATE_W-1:0] FOUT_MIN = RATE_W'(620000000),
  parameter logic [RATE_W-1:0] FOUT_MAX = RATE_W'(700000000)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              clamp_en,
  input  logic [RATE_W-1:0] req_rate,
  input  logic [RATE_W-1:0] ref_rate,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [ND_W-1:0]   nd,
  output logic [FRAC_W-1:0] fracr,
  output logic [RATE_W-1:0] rate_out,
  input  logic              pll_on,
  input  logic              pll_off,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic              cmd_reg,
  output logic [REG_W-1:0]  cmd_mask,
  output logic [REG_W-1:0]  cmd_data
);

  localparam int DW = RATE_W + FRAC_W;
  localparam int CW = $clog2(DW + 1);
  localparam logic [DW-1:0] ND_LIM_W = DW'((2 ** ND_W) - 1);
  localparam logic [DW-1:0] FMASK_W  = DW'((2 ** FRAC_W) - 1);
  localparam logic [DW:0]   HALF     = (DW+1)'(1) << (FRAC_W - 1);
  localparam logic [REG_W-1:0] RSTN_B = REG_W'(1);
  localparam logic [REG_W-1:0] EN_B   = REG_W'(2);
  localparam logic [REG_W-1:0] NDF    = REG_W'((2 ** ND_W) - 1) << ND_LSB;
  localparam logic [REG_W-1:0] FRF    = REG_W'((2 ** FRAC_W) - 1);

  typedef enum logic [2:0] {S_IDLE, S_DIV1, S_CHK1, S_DIV2, S_CHK2, S_RESP} calc_t;

  calc_t             st;
  logic [RATE_W-1:0] ref_q, rem, eff, rem_nx, q1, ach;
  logic [DW-1:0]     quo;
  logic [CW-1:0]     cnt;
  logic [ND_W-1:0]   pend_nd;
  logic [RATE_W:0]   trial;
  logic [DW:0]       prod;
  logic              take, range_bad;

  always_comb begin
    eff = req_rate;
    if (clamp_en && req_rate < FOUT_MIN) eff = FOUT_MIN;
    if (clamp_en && req_rate > FOUT_MAX) eff = FOUT_MAX;
  end

  assign range_bad = !clamp_en && (req_rate < FOUT_MIN || req_rate > FOUT_MAX);

  assign trial  = {rem, quo[DW-1]};
  assign take   = trial >= {1'b0, ref_q};
  assign rem_nx = take ? RATE_W'(trial - {1'b0, ref_q}) : trial[RATE_W-1:0];

  assign q1   = RATE_W'(pend_nd) + RATE_W'(1);
  assign prod = (DW+1)'(ref_q) * (DW+1)'(quo[FRAC_W-1:0]);
  assign ach  = RATE_W'(ref_q * q1) + RATE_W'((prod + HALF) >> FRAC_W);

  assign busy = (st == S_DIV1) || (st == S_CHK1) || (st == S_DIV2) || (st == S_CHK2);
  assign done = (st == S_RESP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ref_q    <= '0;
      quo      <= '0;
      rem      <= '0;
      cnt      <= '0;
      pend_nd  <= '0;
      err      <= 1'b0;
      nd       <= '0;
      fracr    <= '0;
      rate_out <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          ref_q <= ref_rate;
          if (range_bad || ref_rate == '0) begin
            err <= 1'b1;
            st  <= S_RESP;
          end else begin
            quo <= DW'(eff);
            rem <= '0;
            cnt <= CW'(DW);
            st  <= S_DIV1;
          end
        end
        S_DIV1, S_DIV2: begin
          quo <= {quo[DW-2:0], take};
          rem <= rem_nx;
          cnt <= cnt - CW'(1);
          if (cnt == CW'(1)) st <= (st == S_DIV1) ? S_CHK1 : S_CHK2;
        end
        S_CHK1: begin
          if (quo == '0 || quo >= ND_LIM_W) begin
            err <= 1'b1;
            st  <= S_RESP;
          end else begin
            pend_nd <= quo[ND_W-1:0] - ND_W'(1);
            quo     <= {rem, {FRAC_W{1'b0}}} + DW'(ref_q >> 1);
            rem     <= '0;
            cnt     <= CW'(DW);
            st      <= S_DIV2;
          end
        end
        S_CHK2: begin
          if (quo > FMASK_W) begin
            err <= 1'b1;
          end else begin
            err      <= 1'b0;
            nd       <= pend_nd;
            fracr    <= quo[FRAC_W-1:0];
            rate_out <= ach;
          end
          st <= S_RESP;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic              seq_act, seq_dis, seq_last;
  logic [1:0]        seq_idx;
  logic [ND_W-1:0]   cap_nd;
  logic [FRAC_W-1:0] cap_fr;

  assign cmd_valid = seq_act;
  assign seq_last  = seq_dis ? (seq_idx == 2'd1) : (seq_idx == 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_act <= 1'b0;
      seq_dis <= 1'b0;
      seq_idx <= '0;
      cap_nd  <= '0;
      cap_fr  <= '0;
    end else if (!seq_act) begin
      if (pll_on) begin
        seq_act <= 1'b1;
        seq_dis <= 1'b0;
        seq_idx <= '0;
        cap_nd  <= nd;
        cap_fr  <= fracr;
      end else if (pll_off) begin
        seq_act <= 1'b1;
        seq_dis <= 1'b1;
        seq_idx <= '0;
      end
    end else if (cmd_ready) begin
      if (seq_last) seq_act <= 1'b0;
      else          seq_idx <= seq_idx + 2'd1;
    end
  end

  always_comb begin
    cmd_reg  = 1'b0;
    cmd_mask = RSTN_B;
    cmd_data = '0;
    case ({seq_dis, seq_idx})
      3'b001: cmd_data = RSTN_B;
      3'b010: begin
        cmd_reg  = 1'b1;
        cmd_mask = FRF;
        cmd_data = REG_W'(cap_fr);
      end
      3'b011: begin
        cmd_mask = EN_B | NDF;
        cmd_data = EN_B | (REG_W'(cap_nd) << ND_LSB);
      end
      3'b100: cmd_mask = EN_B;
      default: ;
    endcase
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R6
  AST_ERR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    done && err |-> $stable(nd) && $stable(fracr) && $stable(rate_out)); // R7
  AST_ND_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    done && !err |-> nd < ND_W'((2 ** ND_W) - 2)); // R3
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_reg) && $stable(cmd_mask) && $stable(cmd_data)); // R10
  AST_SEQ_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid) |-> !cmd_reg && cmd_data == '0); // R8

endmodule

// File: tb/frac_pll_ctrl_test.sv
module frac_pll_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam longint FMIN = 620000000;
  localparam longint FMAX = 700000000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, clamp_en = 0, pll_on = 0, pll_off = 0, cmd_ready = 0;
  logic [31:0] req_rate = '0, ref_rate = '0;
  logic busy, done, err, cmd_valid, cmd_reg;
  logic [6:0] nd;
  logic [21:0] fracr;
  logic [31:0] rate_out, cmd_mask, cmd_data;

  int total = 0, fails = 0, cycles = 0;
  longint nd_h = 0, fr_h = 0, rate_h = 0;
  logic got_reg [8];
  logic [31:0] got_mask [8], got_data [8];

  frac_pll_ctrl uut (
    .clk(clk), .rst_n(rst_n), .start(start), .clamp_en(clamp_en),
    .req_rate(req_rate), .ref_rate(ref_rate), .busy(busy), .done(done),
    .err(err), .nd(nd), .fracr(fracr), .rate_out(rate_out),
    .pll_on(pll_on), .pll_off(pll_off), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_reg(cmd_reg), .cmd_mask(cmd_mask),
    .cmd_data(cmd_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      total = total + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what);
    total = total + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: %s", req, what);
    end
  endtask

  task automatic model(input longint rq, input longint rf, input bit cl,
                       output bit e, output bit early, output string tag,
                       output longint mnd, output longint mfr, output longint mrate);
    longint eff, q, r;
    eff = rq; e = 0; early = 0; tag = "R5"; mnd = 0; mfr = 0; mrate = 0;
    if (cl && rq < FMIN) begin eff = FMIN; tag = "R1"; end
    if (cl && rq > FMAX) begin eff = FMAX; tag = "R1"; end
    if (!cl && (rq < FMIN || rq > FMAX)) begin e = 1; early = 1; tag = "R2"; end
    else if (rf == 0) begin e = 1; early = 1; tag = "R3"; end
    else begin
      q = eff / rf; r = eff % rf;
      if (q == 0 || q >= 127) begin e = 1; tag = "R3"; end
      else begin
        mfr = (r * 64'd4194304 + rf / 2) / rf;
        if (mfr > 4194303) begin e = 1; tag = "R4"; end
        else begin
          mnd = q - 1;
          mrate = rf * q + (rf * mfr + 64'd2097152) / 64'd4194304;
        end
      end
    end
  endtask

  task automatic wait_done();
    int g = 0;
    while (!done && g < 400) begin @(negedge clk); g++; end
    if (g >= 400) check(0, "R6", "done never rose, actual 0 expected 1");
  endtask

  task automatic run_case(input longint rq, input longint rf, input bit cl);
    bit e, early; string tag; longint mnd, mfr, mrate;
    model(rq, rf, cl, e, early, tag, mnd, mfr, mrate);
    @(negedge clk);
    start = 1; clamp_en = cl; req_rate = 32'(rq); ref_rate = 32'(rf);
    @(negedge clk);
    start = 0;
    if (early)
      check(done && !busy, "R6", $sformatf("early reject timing, actual done=%0b busy=%0b expected 1/0", done, busy));
    else
      check(busy && !done, "R6", $sformatf("busy after start, actual busy=%0b done=%0b expected 1/0", busy, done));
    wait_done();
    if (e) begin
      check(err && nd == nd_h && fracr == fr_h && rate_out == rate_h, {tag, "/R7"},
            $sformatf("req=%0d ref=%0d actual err=%0b nd=%0d fr=%0d rate=%0d expected 1 %0d %0d %0d",
                      rq, rf, err, nd, fracr, rate_out, nd_h, fr_h, rate_h));
    end else begin
      check(!err && nd == mnd && fracr == mfr && rate_out == mrate, tag,
            $sformatf("req=%0d ref=%0d cl=%0b actual err=%0b nd=%0d fr=%0d rate=%0d expected 0 %0d %0d %0d",
                      rq, rf, cl, err, nd, fracr, rate_out, mnd, mfr, mrate));
      nd_h = mnd; fr_h = mfr; rate_h = mrate;
    end
  endtask

  task automatic collect(input int n, input int stall_mod);
    int i = 0, g = 0, ph = 0;
    while (i < n && g < 200) begin
      @(negedge clk);
      g++; ph++;
      cmd_ready = (stall_mod == 0) ? 1'b1 : ((ph % stall_mod) != 0);
      if (cmd_valid && cmd_ready) begin
        got_reg[i] = cmd_reg; got_mask[i] = cmd_mask; got_data[i] = cmd_data;
        i++;
      end
    end
    @(negedge clk);
    cmd_ready = 0;
    if (i < n) check(0, "R10", $sformatf("commands collected, actual %0d expected %0d", i, n));
  endtask

  task automatic check_on(input longint end_nd, input longint efr, input string req);
    logic [31:0] em [4], ed [4];
    logic er [4];
    er[0] = 0; em[0] = 32'h1;     ed[0] = 32'h0;
    er[1] = 0; em[1] = 32'h1;     ed[1] = 32'h1;
    er[2] = 1; em[2] = 32'h3FFFFF; ed[2] = 32'(efr);
    er[3] = 0; em[3] = 32'h1FE;   ed[3] = 32'h2 | (32'(end_nd) << 2);
    for (int k = 0; k < 4; k++)
      check(got_reg[k] == er[k] && got_mask[k] == em[k] && got_data[k] == ed[k], req,
            $sformatf("on cmd %0d actual %0b/%h/%h expected %0b/%h/%h",
                      k, got_reg[k], got_mask[k], got_data[k], er[k], em[k], ed[k]));
  endtask

  task automatic check_idle(input int n, input string req);
    bit seen = 0;
    for (int k = 0; k < n; k++) begin @(negedge clk); if (cmd_valid) seen = 1; end
    check(!seen, req, $sformatf("extra command offered, actual valid=%0b expected 0", seen));
  endtask

  initial begin
    longint refs [9];
    logic [31:0] hm, hd; logic hr; bit stable_ok;
    bit e, early; string tag; longint mnd, mfr, mrate;
    refs[0] = 12000000; refs[1] = 24576000; refs[2] = 19200000; refs[3] = 10000000;
    refs[4] = 6000000;  refs[5] = 27000000; refs[6] = 5000000;  refs[7] = 8388608;
    refs[8] = 750000000;

    repeat (3) @(negedge clk);
    check(!busy && !done && !err && !cmd_valid && nd == 0 && fracr == 0 && rate_out == 0, "R7",
          $sformatf("reset state, actual busy=%0b done=%0b err=%0b valid=%0b nd=%0d fr=%0d rate=%0d expected all 0",
                    busy, done, err, cmd_valid, nd, fracr, rate_out));
    rst_n = 1;

    for (int ri = 0; ri < 9; ri++)
      for (int k = 0; k < 15; k++)
        for (int c = 0; c < 2; c++)
          run_case(600000000 + longint'(k) * 7333337, refs[ri], c[0]);

    run_case(0, 12000000, 1);          // R1 zero clamps up
    run_case(0, 12000000, 0);          // R2 zero rejected
    run_case(650000000, 0, 0);         // R3 zero reference
    run_case(650000000, 0, 1);         // R3 zero reference
    run_case(629999999, 10000000, 0);  // R4 fraction rounds to 2^22
    run_case(620756993, 8388608, 0);   // R4 exact half rounds up
    run_case(640000000, 5000000, 0);   // R3 quotient 128
    run_case(700000000, 12000000, 0);  // R5 upper edge
    run_case(620000000, 12000000, 0);  // R5 lower edge

    // R6: start while busy is ignored
    model(655000000, 12288000, 0, e, early, tag, mnd, mfr, mrate);
    @(negedge clk); start = 1; clamp_en = 0; req_rate = 655000000; ref_rate = 12288000;
    @(negedge clk); start = 0;
    repeat (5) @(negedge clk);
    start = 1; req_rate = 690000000; ref_rate = 24000000;
    @(negedge clk); start = 0;
    wait_done();
    check(!err && nd == mnd && fracr == mfr && rate_out == mrate, "R6",
          $sformatf("start during busy, actual nd=%0d fr=%0d rate=%0d expected %0d %0d %0d",
                    nd, fracr, rate_out, mnd, mfr, mrate));
    nd_h = mnd; fr_h = mfr; rate_h = mrate;
    @(negedge clk);
    check(!done, "R6", $sformatf("done width, actual %0b expected 0", done));

    // R8 / R10: switch-on with stalls
    cmd_ready = 0;
    @(negedge clk); pll_on = 1; @(negedge clk); pll_on = 0;
    hr = cmd_reg; hm = cmd_mask; hd = cmd_data; stable_ok = cmd_valid;
    repeat (4) begin @(negedge clk); if (!cmd_valid || cmd_reg != hr || cmd_mask != hm || cmd_data != hd) stable_ok = 0; end
    check(stable_ok, "R10", $sformatf("stall hold, actual valid=%0b expected held", cmd_valid));
    collect(4, 3);
    check_on(nd_h, fr_h, "R8");
    check_idle(4, "R8");

    // R9: switch-off
    @(negedge clk); pll_off = 1; @(negedge clk); pll_off = 0;
    collect(2, 2);
    check(got_reg[0] == 0 && got_mask[0] == 32'h2 && got_data[0] == 0, "R9",
          $sformatf("off cmd 0 actual %0b/%h/%h expected 0/00000002/00000000", got_reg[0], got_mask[0], got_data[0]));
    check(got_reg[1] == 0 && got_mask[1] == 32'h1 && got_data[1] == 0, "R9",
          $sformatf("off cmd 1 actual %0b/%h/%h expected 0/00000001/00000000", got_reg[1], got_mask[1], got_data[1]));
    check_idle(3, "R9");

    // R11: capture at strobe, strobes ignored while active
    begin
      longint snd, sfr;
      snd = nd_h; sfr = fr_h;
      @(negedge clk); pll_on = 1; @(negedge clk); pll_on = 0;
      pll_off = 1; @(negedge clk); pll_off = 0;
      run_case(680000000, 19200000, 0);
      check(nd_h != snd || fr_h != sfr, "R11", "new request changed fields, actual same expected different");
      collect(4, 0);
      check_on(snd, sfr, "R11");
      check_idle(4, "R11");
    end

    // R11: both strobes together run switch-on
    @(negedge clk); pll_on = 1; pll_off = 1; @(negedge clk); pll_on = 0; pll_off = 0;
    collect(4, 0);
    check_on(nd_h, fr_h, "R11");
    check_idle(3, "R11");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule